// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers that sits behind a simple single-cycle register port of a workstation I/O controller. It holds four plain byte registers: a configuration byte, a general auxiliary byte, a diagnostic byte and a modem-control byte. It also holds a power-status byte, a word-wide system-control register and a write-only power-management strobe location. Software uses these to arm the power-fail interrupt, to request a shutdown, to request a system reset and to halt the CPU.

A power-fail input feeds a latched status flag. That flag is gated by an enable bit in the configuration byte and drives an interrupt output. Software clears the flag through a dedicated bit of the power-status byte. Shutdown, system-reset and halt requests leave the block as one-clock pulses. Reset deliberately leaves the diagnostic byte and the system-control word untouched, so their contents survive a reset that the block itself requested.

Top module: `auxctl_regs`

## Requirements
- R1: `pf_irq` is high exactly when power-status bit 2 (the power-fail flag) and configuration bit 3 (the power-fail enable) are both set.
- R2: On each clock edge where `pf_in` differs from its value at the previous edge, the power-fail flag becomes `pf_in AND` configuration bit 3. A high `pf_in` while the enable is clear therefore leaves the flag at 0.
- R3: A write to the power-status byte (address 0x02) keeps only data bits 1:0 and carries the current power-fail flag into bit 2. If data bit 1 is set, the stored value becomes data bit 0 alone, which clears the flag.
- R4: When a power-status write leaves bit 0 of the stored value set, `shutdown_req` pulses high for one cycle, in the cycle after the write.
- R5: Any write to the power-management location (address 0x08) pulses `halt_req` for one cycle after the write, for any data value. Reads of that location return 0.
- R6: A write to the system-control word (address 0x10) with data bit 0 set loads 0x00000002 into it and pulses `sysreset_req` in the cycle after the write. A write there with bit 0 clear changes nothing.
- R7: Addresses 0x11 to 0x13 of the system-control window read as 0, and writes to them are ignored.
- R8: Synchronous reset clears the configuration, auxiliary, power-status and modem-control bytes. The diagnostic byte and the system-control word keep their values.
- R9: The configuration (0x00), auxiliary (0x01), diagnostic (0x03) and modem-control (0x04) bytes store all 8 data bits and read back unchanged in `rdata[7:0]`, with upper bits zero.
- R10: A configuration write takes effect on `pf_irq` in the cycle after the write, using the new enable bit, and does not alter the power-fail flag.
- R11: Read data is registered: `rdata` shows the addressed value in the cycle after `rd_en` and is 0 otherwise. Unmapped addresses read 0, and writes to them raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (5) | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| pf_in | input | 1 | Power-fail indication |
| pf_irq | output | 1 | Power-fail interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysreset_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle CPU halt request |

## Verification
The bench probes the power-fail flag from each side. It sets the flag with and without the enable, clears it through the status byte and through a falling input, and checks that a plain status write keeps it. A design that dropped the flag on an ordinary status write, or that latched it while disabled, would show a wrong status read or a stray interrupt. The bench toggles the enable with the flag held to show that the interrupt follows the new configuration at once without losing the flag. It also resets the block after loading every register, to catch a design that wipes the diagnostic or system-control contents. Finally it sends system-control writes with bit 0 clear, and to the upper offsets of that window, which a loose decoder would turn into spurious reset requests.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;

    // Byte offsets inside the block's register window
    localparam int OFF_CFG    = 'h00;
    localparam int OFF_AUX    = 'h01;
    localparam int OFF_PSTAT  = 'h02;
    localparam int OFF_DIAG   = 'h03;
    localparam int OFF_MODEM  = 'h04;
    localparam int OFF_PMGT   = 'h08;
    localparam int OFF_SYSWIN = 'h10;   // 4-byte window, only first byte offset live

    // Bit positions
    localparam int PF_FLAG_BIT = 2;     // power-status: latched power-fail
    localparam int PF_EN_BIT   = 3;     // configuration: power-fail enable
    localparam int PS_CLR_BIT  = 1;     // power-status write: clear request
    localparam int PS_OFF_BIT  = 0;     // power-status: shutdown bit
    localparam int SYS_GO_BIT  = 0;     // system-control write: reset trigger

    localparam logic [31:0] SYS_LOAD_VAL = 32'h0000_0002;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_AUX,
        SEL_PSTAT,
        SEL_DIAG,
        SEL_MODEM,
        SEL_PMGT,
        SEL_SYS0,
        SEL_SYSX
    } sel_e;

    // Request pulse bundle
    typedef struct packed {
        logic shutdown;
        logic sysreset;
        logic halt;
    } req_t;

    localparam int REQ_N = $bits(req_t);

    // Value stored by a power-status write given the flag it must carry
    function automatic logic [7:0] pstat_merge(input logic [1:0] wd, input logic flag);
        logic [7:0] v;
        v = 8'h00;
        v[1:0] = wd;
        v[PF_FLAG_BIT] = flag;
        if (wd[PS_CLR_BIT]) begin
            v = 8'h00;
            v[PS_OFF_BIT] = wd[PS_OFF_BIT];
        end
        return v;
    endfunction

endpackage

// File: rtl/auxctl_decode.sv
module auxctl_decode
    import auxctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int WIN_LSB = 2;

    logic in_sys_win;

    assign in_sys_win = (addr[ADDR_W-1:WIN_LSB] == OFF_SYSWIN[ADDR_W-1:WIN_LSB]);

    always_comb begin
        sel = SEL_NONE;
        if (in_sys_win) begin
            sel = (addr[WIN_LSB-1:0] == '0) ? SEL_SYS0 : SEL_SYSX;
        end else begin
            case (addr)
                ADDR_W'(OFF_CFG):   sel = SEL_CFG;
                ADDR_W'(OFF_AUX):   sel = SEL_AUX;
                ADDR_W'(OFF_PSTAT): sel = SEL_PSTAT;
                ADDR_W'(OFF_DIAG):  sel = SEL_DIAG;
                ADDR_W'(OFF_MODEM): sel = SEL_MODEM;
                ADDR_W'(OFF_PMGT):  sel = SEL_PMGT;
                default:            sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/auxctl_pwrfail.sv
module auxctl_pwrfail
    import auxctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pf_in,
    input  logic       gate_en,
    input  logic       ps_wr,
    input  logic [1:0] ps_wd,
    output logic [7:0] pstat_q,
    output logic       irq,
    output logic       off_now
);
    logic       pf_prev;
    logic       pf_evt;
    logic       flag_mid;
    logic [7:0] ps_next;

    assign pf_evt   = pf_in ^ pf_prev;
    assign flag_mid = pf_evt ? (pf_in & gate_en) : pstat_q[PF_FLAG_BIT];
    assign ps_next  = pstat_merge(ps_wd, flag_mid);
    assign off_now  = ps_wr & ps_next[PS_OFF_BIT];
    assign irq      = pstat_q[PF_FLAG_BIT] & gate_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pstat_q <= 8'h00;
            pf_prev <= 1'b0;
        end else begin
            pf_prev <= pf_in;
            if (ps_wr) begin
                pstat_q <= ps_next;
            end else if (pf_evt) begin
                pstat_q[PF_FLAG_BIT] <= pf_in & gate_en;
            end
        end
    end

    // R3: clear bit in a status write always drops the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (ps_wr && ps_wd[PS_CLR_BIT]) |=> !pstat_q[PF_FLAG_BIT]);

    // R2: enabled rising power-fail latches the flag unless cleared same cycle
    p_pf_set_r2: assert property (@(posedge clk) disable iff (rst)
        (pf_in && !pf_prev && gate_en && !(ps_wr && ps_wd[PS_CLR_BIT]))
        |=> pstat_q[PF_FLAG_BIT]);

    // R2: power-fail change while disabled never leaves the flag set
    p_pf_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (pf_evt && !gate_en) |=> !pstat_q[PF_FLAG_BIT]);
endmodule

// File: rtl/auxctl_pulse.sv
module auxctl_pulse #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= fire[i];
        end
    end
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
    import auxctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pf_in,
    output logic              pf_irq,
    output logic              shutdown_req,
    output logic              sysreset_req,
    output logic              halt_req
);
    localparam int BYTE_W   = 8;
    localparam int NBYTE    = 4;
    localparam int IX_CFG   = 0;
    localparam int IX_AUX   = 1;
    localparam int IX_DIAG  = 2;
    localparam int IX_MODEM = 3;
    // bytes cleared by reset: all except diagnostic
    localparam logic [NBYTE-1:0] CLR_ON_RST = 4'b1011;

    sel_e              sel;
    logic [NBYTE-1:0]  byte_we;
    logic [BYTE_W-1:0] byte_q [NBYTE];
    logic [7:0]        pstat_q;
    logic              off_now;
    logic              sys_set;
    logic [DATA_W-1:0] sys_q;
    logic [DATA_W-1:0] rd_mux;
    req_t              fire;
    req_t              req_q;

    auxctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign byte_we[IX_CFG]   = wr_en && (sel == SEL_CFG);
    assign byte_we[IX_AUX]   = wr_en && (sel == SEL_AUX);
    assign byte_we[IX_DIAG]  = wr_en && (sel == SEL_DIAG);
    assign byte_we[IX_MODEM] = wr_en && (sel == SEL_MODEM);

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        if (CLR_ON_RST[i]) begin : g_clr
            always_ff @(posedge clk) begin
                if (rst)             byte_q[i] <= '0;
                else if (byte_we[i]) byte_q[i] <= wdata[BYTE_W-1:0];
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (byte_we[i]) byte_q[i] <= wdata[BYTE_W-1:0];
            end
        end
    end

    auxctl_pwrfail u_pf (
        .clk     (clk),
        .rst     (rst),
        .pf_in   (pf_in),
        .gate_en (byte_q[IX_CFG][PF_EN_BIT]),
        .ps_wr   (wr_en && (sel == SEL_PSTAT)),
        .ps_wd   (wdata[1:0]),
        .pstat_q (pstat_q),
        .irq     (pf_irq),
        .off_now (off_now)
    );

    // System-control word: not touched by reset
    assign sys_set = wr_en && (sel == SEL_SYS0) && wdata[SYS_GO_BIT];

    always_ff @(posedge clk) begin
        if (sys_set) sys_q <= DATA_W'(SYS_LOAD_VAL);
    end

    always_comb begin
        fire          = '0;
        fire.shutdown = off_now;
        fire.sysreset = sys_set;
        fire.halt     = wr_en && (sel == SEL_PMGT);
    end

    auxctl_pulse #(.N(REQ_N)) u_req (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .q    (req_q)
    );

    assign shutdown_req = req_q.shutdown;
    assign sysreset_req = req_q.sysreset;
    assign halt_req     = req_q.halt;

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CFG:   rd_mux[BYTE_W-1:0] = byte_q[IX_CFG];
            SEL_AUX:   rd_mux[BYTE_W-1:0] = byte_q[IX_AUX];
            SEL_PSTAT: rd_mux[BYTE_W-1:0] = pstat_q;
            SEL_DIAG:  rd_mux[BYTE_W-1:0] = byte_q[IX_DIAG];
            SEL_MODEM: rd_mux[BYTE_W-1:0] = byte_q[IX_MODEM];
            SEL_SYS0:  rd_mux             = sys_q;
            default:   rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

    // R5: halt follows a power-management write with zero data
    p_halt_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_PMGT) && (wdata == '0)) |=> halt_req);

    // R5: halt follows a power-management write with non-zero data
    p_halt_data_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_PMGT) && (wdata != '0)) |=> halt_req);

    // R6: triggering write loads the fixed value and requests reset
    p_sysrst_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_SYS0) && wdata[SYS_GO_BIT])
        |=> (sysreset_req && (sys_q == DATA_W'(SYS_LOAD_VAL))));

    // R7: writes to the unused window offsets leave the word alone
    p_syswin_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_SYSX)) |=> ($stable(sys_q) && !sysreset_req));

    // R4: a shutdown pulse only follows a stored shutdown bit
    p_shut_r4: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> pstat_q[PS_OFF_BIT]);

    // R11: without a read strobe the read bus returns zero
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));
endmodule

// File: tb/tb_auxctl_regs.sv
`timescale 1ns/1ps
module tb_auxctl_regs;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              pf_in = 1'b0;
    logic              pf_irq;
    logic              shutdown_req;
    logic              sysreset_req;
    logic              halt_req;

    int n_chk = 0;
    int n_bad = 0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              rd_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    auxctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pf_in(pf_in), .pf_irq(pf_irq),
        .shutdown_req(shutdown_req), .sysreset_req(sysreset_req),
        .halt_req(halt_req)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when read data is due
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read", rdata, '0);
            end else begin
                logic [DATA_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata == e, t, rdata, e);
            end
        end else begin
            check(rdata == '0, "R11 idle read bus", rdata, '0);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = ADDR_W'(a); rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // called right after wr(): pulses from that write are visible now
    task automatic pulses(input logic sd, input logic rr, input logic h, input string tag);
        check(shutdown_req == sd, {tag, " shutdown"}, 32'(shutdown_req), 32'(sd));
        check(sysreset_req == rr, {tag, " sysreset"}, 32'(sysreset_req), 32'(rr));
        check(halt_req == h, {tag, " halt"}, 32'(halt_req), 32'(h));
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pf_in = v;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state (R8)
        rd('h00, 32'h0, "R8 cfg after reset");
        rd('h01, 32'h0, "R8 aux after reset");
        rd('h02, 32'h0, "R8 pstat after reset");
        rd('h04, 32'h0, "R8 modem after reset");
        check(pf_irq == 1'b0, "R1 irq after reset", 32'(pf_irq), 32'h0);

        // R9 plain byte read-back, upper data bits dropped
        wr('h00, 32'hFFFF_FF00); rd('h00, 32'h0000_0000, "R9 cfg");
        wr('h01, 32'h1234_563C); rd('h01, 32'h0000_003C, "R9 aux");
        wr('h03, 32'h0000_0096); rd('h03, 32'h0000_0096, "R9 diag");
        wr('h04, 32'hABCD_EFF0); rd('h04, 32'h0000_00F0, "R9 modem");

        // R2/R1: enabled power fail sets flag and irq
        wr('h00, 32'h08);
        set_pf(1'b1);
        check(pf_irq == 1'b1, "R1 irq with flag and enable", 32'(pf_irq), 32'h1);
        rd('h02, 32'h04, "R2 flag latched");

        // R10: enable toggled, flag kept
        wr('h00, 32'h00);
        check(pf_irq == 1'b0, "R10 irq drops with enable", 32'(pf_irq), 32'h0);
        rd('h02, 32'h04, "R10 flag kept when disabled");
        wr('h00, 32'h08);
        check(pf_irq == 1'b1, "R10 irq returns with enable", 32'(pf_irq), 32'h1);

        // R3: plain status writes keep the flag
        wr('h02, 32'h00); pulses(1'b0, 1'b0, 1'b0, "R4 no shutdown on zero");
        rd('h02, 32'h04, "R3 flag preserved");
        wr('h02, 32'hFC);
        rd('h02, 32'h04, "R3 upper bits dropped");
        check(pf_irq == 1'b1, "R3 irq still on", 32'(pf_irq), 32'h1);
        // clear
        wr('h02, 32'h02);
        rd('h02, 32'h00, "R3 clear bit drops flag");
        check(pf_irq == 1'b0, "R3 irq after clear", 32'(pf_irq), 32'h0);

        // R4: shutdown pulses
        wr('h02, 32'h01); pulses(1'b1, 1'b0, 1'b0, "R4 shutdown bit");
        @(negedge clk);
        check(shutdown_req == 1'b0, "R4 single pulse", 32'(shutdown_req), 32'h0);
        rd('h02, 32'h01, "R4 stored bit0");
        wr('h02, 32'h03); pulses(1'b1, 1'b0, 1'b0, "R4 shutdown with clear");
        rd('h02, 32'h01, "R3 clear keeps only bit0");
        wr('h02, 32'h00);

        // R2: falling input clears; disabled input never sets
        set_pf(1'b0);
        set_pf(1'b1);
        rd('h02, 32'h04, "R2 re-latched");
        set_pf(1'b0);
        rd('h02, 32'h00, "R2 falling input clears");
        wr('h00, 32'h00);
        set_pf(1'b1);
        rd('h02, 32'h00, "R2 disabled no latch");
        check(pf_irq == 1'b0, "R2 no irq disabled", 32'(pf_irq), 32'h0);
        set_pf(1'b0);

        // R5: halt on any data
        wr('h08, 32'h0); pulses(1'b0, 1'b0, 1'b1, "R5 halt zero data");
        wr('h08, 32'hDEAD_BEEF); pulses(1'b0, 1'b0, 1'b1, "R5 halt data");
        rd('h08, 32'h0, "R5 pmgt reads zero");

        // R6: system-control
        wr('h10, 32'hFFFF_FFFE); pulses(1'b0, 1'b0, 1'b0, "R6 bit0 clear");
        wr('h10, 32'h0000_0001); pulses(1'b0, 1'b1, 1'b0, "R6 reset request");
        rd('h10, 32'h0000_0002, "R6 loaded value");

        // R7: unused window offsets
        wr('h11, 32'h1); pulses(1'b0, 1'b0, 1'b0, "R7 offset 1 write");
        wr('h13, 32'hFFFF_FFFF); pulses(1'b0, 1'b0, 1'b0, "R7 offset 3 write");
        rd('h12, 32'h0, "R7 offset 2 read");
        rd('h10, 32'h0000_0002, "R7 word unchanged");

        // R11: unmapped
        wr('h1F, 32'h1); pulses(1'b0, 1'b0, 1'b0, "R11 unmapped write");
        wr('h06, 32'hFF); pulses(1'b0, 1'b0, 1'b0, "R11 unmapped write 2");
        rd('h06, 32'h0, "R11 unmapped read");

        // R8: reset keeps diag and system-control
        wr('h00, 32'h5A); wr('h01, 32'h11); wr('h03, 32'hC3); wr('h04, 32'h77);
        wr('h02, 32'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd('h00, 32'h0, "R8 cfg cleared");
        rd('h01, 32'h0, "R8 aux cleared");
        rd('h02, 32'h0, "R8 pstat cleared");
        rd('h04, 32'h0, "R8 modem cleared");
        rd('h03, 32'hC3, "R8 diag kept");
        rd('h10, 32'h2, "R8 sysctl kept");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule